// File: doc/BRIEF.md
# Periodic Comparator Timer Channel

This block is one channel of a free-running timer. It watches a shared main counter and raises a one-clock fire strobe when the counter reaches the channel's comparator. The channel has two modes. In one-shot mode it fires once and then stays quiet until software writes to it again. In periodic mode it keeps a separate period register and moves the comparator forward after every expiry, so that it fires again one period later.

Software reaches the channel through two write ports. The configuration write merges data under a bit mask. The comparator write also merges under a mask and, in periodic mode, loads the period. A main enable input starts and stops the whole channel. Each time the channel is armed, or re-armed by a write, it compares the comparator with both the live counter and the counter value that software last read. If the comparator lies behind, a one-shot channel fires at once. A periodic channel instead rounds its comparator forward by whole periods until it sits ahead of the counter.

That rounding uses a remainder computed one bit per cycle. Firing stays stalled until the remainder is ready.

Top module: `tmr_channel`

## Requirements
- R1: After reset, fire_o and irq_o are low, cmp_o is all ones, period_o is zero, and cfg_o holds only the capability fields: 32'h0F04_0010 with the default parameters.
- R2: Configuration layout:
  - Bit 0 is the interrupt enable, bit 1 selects periodic mode and bit 2 is the value-set bit.
  - Bits 12:8 are a route number.
  - Writable bits take data where the mask is 1 and keep their value where the mask is 0.
  - Bit 4 (periodic capable), bit 5 (message capable), bit 6 (64-bit capable) and bits 31:16 (allowed routes) are read-only.
  - Bit 3 (force 32-bit) always reads 0.
- R3: In one-shot mode a comparator write sets cmp_o to (old & ~mask) | (data & mask).
- R4: In periodic mode a comparator write merges the data into period_o under the mask. It changes cmp_o only when the value-set bit is 1.
- R5: A configuration write that leaves bit 1 at 0 forces period_o to zero.
- R6: While enabled and armed, cnt_i equal to cmp_o raises fire_o for exactly one clock. irq_o is fire_o gated by configuration bit 0.
- R7: In one-shot mode the channel disarms after it fires and does not fire again until it is re-armed.
- R8: Arming events are a rising en_i, a configuration write while enabled, and a comparator write while enabled. On such an event a one-shot channel fires in the following cycle if (cmp − cnt) > (cmp − snap) or cmp = cnt, using wrapping arithmetic.
- R9: After a periodic fire with a nonzero period, cmp_o becomes cmp + ((cnt − cmp) / period + 1) × period (32-bit wrapping). This takes 34 cycles. The channel then fires again at the new value, provided the counter holds each value for at least 34 cycles.
- R10: When a periodic channel is armed with its comparator behind, it fires nothing. Its comparator is rounded forward with the R9 formula.
- R11: While en_i is low nothing fires, and the channel stays disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cnt_i | input | CNT_W | Shared main counter value |
| snap_i | input | CNT_W | Counter value last read by software |
| en_i | input | 1 | Main counter enable |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_wmask_i | input | 32 | Configuration write mask |
| cmp_wr_i | input | 1 | Comparator write strobe |
| cmp_wdata_i | input | CNT_W | Comparator write data |
| cmp_wmask_i | input | CNT_W | Comparator write mask |
| fire_o | output | 1 | One-clock expiry strobe |
| irq_o | output | 1 | Expiry strobe gated by interrupt enable |
| cfg_o | output | 32 | Configuration register |
| cmp_o | output | CNT_W | Live comparator |
| period_o | output | CNT_W | Period register |

## Verification
The expiry path is driven in three ways:
- A counter stepping once per clock up to a one-shot comparator separates the single-cycle strobe from a level, and the fire-once behaviour from repeated firing.
- A counter held for many cycles per step through several periods shows whether the comparator advances by exactly one period after an on-time match.
- Arming events placed with the comparator between the last-read value and the live counter separate the immediate one-shot fire from the silent periodic catch-up.

Random periods, comparators and lateness then compare the rounded comparator against a true division computed in the bench. This exposes any error in the remainder path.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CFG_W    = 32;
   localparam int B_IRQ_EN = 0;
   localparam int B_PERIOD = 1;
   localparam int B_VALSET = 2;
   localparam int B_WIDE   = 3;
   localparam int B_PERCAP = 4;
   localparam int B_MSGCAP = 5;
   localparam int B_SZCAP  = 6;
   localparam int ROUTE_LO = 8;
   localparam int ROUTE_W  = 5;
   localparam int ALLOW_LO = 16;
   localparam int ALLOW_W  = 16;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_ARMED = 2'd2,
      ST_CALC  = 2'd3
   } tmr_st_e;
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
   import tmr_pkg::*;
#(
   parameter bit                 PER_CAP  = 1'b1,
   parameter bit                 MSG_CAP  = 1'b0,
   parameter bit                 WIDE_CAP = 1'b0,
   parameter logic [ALLOW_W-1:0] ALLOWED  = 16'h0F04
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [CFG_W-1:0] data_i,
   input  logic [CFG_W-1:0] mask_i,
   output logic [CFG_W-1:0] cfg_o,
   output logic             periodic_next_o
);
   localparam logic [CFG_W-1:0] ROUTE_BITS = ((CFG_W'(1) << ROUTE_W) - CFG_W'(1)) << ROUTE_LO;
   localparam logic [CFG_W-1:0] CAP_BITS   = (CFG_W'(ALLOWED) << ALLOW_LO)
                                           | (CFG_W'(PER_CAP) << B_PERCAP)
                                           | (CFG_W'(MSG_CAP) << B_MSGCAP)
                                           | (CFG_W'(WIDE_CAP) << B_SZCAP);
   localparam logic [CFG_W-1:0] BASE_RW    = ROUTE_BITS | (CFG_W'(1) << B_IRQ_EN)
                                           | (CFG_W'(1) << B_VALSET);

   logic [CFG_W-1:0] rw_mask;
   logic [CFG_W-1:0] rw_q, rw_d;

   generate
      if (PER_CAP) begin : g_per_rw
         assign rw_mask = BASE_RW | (CFG_W'(1) << B_PERIOD);
      end else begin : g_per_ro
         assign rw_mask = BASE_RW;
      end
   endgenerate

   always_comb begin
      rw_d = rw_q;
      if (wr_i) rw_d = (rw_q & ~(mask_i & rw_mask)) | (data_i & mask_i & rw_mask);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rw_q <= '0;
      else         rw_q <= rw_d;
   end

   assign cfg_o           = rw_q | CAP_BITS;
   assign periodic_next_o = rw_d[B_PERIOD];

   assert_irq_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && mask_i[B_IRQ_EN]) |=> (cfg_o[B_IRQ_EN] == $past(data_i[B_IRQ_EN])));
   assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(cfg_o));
   assert_wide_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> !cfg_o[B_WIDE]);
endmodule

// File: rtl/tmr_rem_div.sv
module tmr_rem_div #(
   parameter int W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic         done_o,
   output logic [W-1:0] rem_o
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  dvd_q, dvs_q, rem_q;
   logic [CW-1:0] left_q;
   logic          busy_q, done_q;
   logic [W:0]    trial, diff;

   assign trial = {rem_q, dvd_q[W-1]};
   assign diff  = trial - {1'b0, dvs_q};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dvd_q  <= '0;
         dvs_q  <= '0;
         rem_q  <= '0;
         left_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            dvd_q  <= dividend_i;
            dvs_q  <= divisor_i;
            rem_q  <= '0;
            left_q <= CW'(W);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (trial >= {1'b0, dvs_q}) rem_q <= diff[W-1:0];
            else                        rem_q <= trial[W-1:0];
            dvd_q  <= dvd_q << 1;
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign rem_o  = rem_q;

   assert_rem_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_q && dvs_q != '0) |-> (rem_q < dvs_q));
   assert_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (busy_q && !done_q));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int                 CNT_W    = 32,
   parameter bit                 PER_CAP  = 1'b1,
   parameter bit                 MSG_CAP  = 1'b0,
   parameter bit                 WIDE_CAP = 1'b0,
   parameter logic [ALLOW_W-1:0] ALLOWED  = 16'h0F04
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] snap_i,
   input  logic             en_i,
   input  logic             cfg_wr_i,
   input  logic [31:0]      cfg_wdata_i,
   input  logic [31:0]      cfg_wmask_i,
   input  logic             cmp_wr_i,
   input  logic [CNT_W-1:0] cmp_wdata_i,
   input  logic [CNT_W-1:0] cmp_wmask_i,
   output logic             fire_o,
   output logic             irq_o,
   output logic [31:0]      cfg_o,
   output logic [CNT_W-1:0] cmp_o,
   output logic [CNT_W-1:0] period_o
);
   localparam logic [CNT_W-1:0] CMP_RST = '1;

   generate
      if (CNT_W < 8 || CNT_W > 64) begin : g_bad_width
         $error("tmr_channel: CNT_W must lie in 8..64");
      end
   endgenerate

   logic             per_next;
   logic [CNT_W-1:0] cmp_q, per_q, base_q, div_rem, cmp_merge, per_merge;
   logic             en_q, hit, behind, rearm, can_repeat, periodic, val_set;
   logic             div_start, div_done, fire;
   tmr_st_e          st_q, st_d;

   tmr_cfg_reg #(
      .PER_CAP(PER_CAP), .MSG_CAP(MSG_CAP), .WIDE_CAP(WIDE_CAP), .ALLOWED(ALLOWED)
   ) u_cfg (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(cfg_wr_i),
      .data_i(cfg_wdata_i), .mask_i(cfg_wmask_i),
      .cfg_o(cfg_o), .periodic_next_o(per_next)
   );

   tmr_rem_div #(.W(CNT_W)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
      .dividend_i(cnt_i - cmp_q), .divisor_i(per_q),
      .done_o(div_done), .rem_o(div_rem)
   );

   assign periodic   = cfg_o[B_PERIOD];
   assign val_set    = cfg_o[B_VALSET];
   assign can_repeat = periodic && (per_q != '0);
   assign hit        = (cnt_i == cmp_q);
   assign behind     = (cmp_q - cnt_i) > (cmp_q - snap_i);
   assign rearm      = (en_i && !en_q) || cfg_wr_i || cmp_wr_i;
   assign cmp_merge  = (cmp_q & ~cmp_wmask_i) | (cmp_wdata_i & cmp_wmask_i);
   assign per_merge  = (per_q & ~cmp_wmask_i) | (cmp_wdata_i & cmp_wmask_i);

   always_comb begin
      st_d      = st_q;
      fire      = 1'b0;
      div_start = 1'b0;
      case (st_q)
         ST_CHECK: begin
            if (hit || (behind && !can_repeat)) begin
               fire      = 1'b1;
               div_start = can_repeat;
               st_d      = can_repeat ? ST_CALC : ST_IDLE;
            end else if (behind) begin
               div_start = 1'b1;
               st_d      = ST_CALC;
            end else begin
               st_d = ST_ARMED;
            end
         end
         ST_ARMED: begin
            if (hit) begin
               fire      = 1'b1;
               div_start = can_repeat;
               st_d      = can_repeat ? ST_CALC : ST_IDLE;
            end
         end
         ST_CALC: begin
            if (div_done) st_d = ST_ARMED;
         end
         default: ;
      endcase
      if (!en_i) begin
         st_d      = ST_IDLE;
         fire      = 1'b0;
         div_start = 1'b0;
      end else if (rearm) begin
         st_d      = ST_CHECK;
         fire      = 1'b0;
         div_start = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         en_q   <= 1'b0;
         cmp_q  <= CMP_RST;
         per_q  <= '0;
         base_q <= '0;
      end else begin
         st_q <= st_d;
         en_q <= en_i;
         if (div_start) base_q <= cnt_i;
         if (st_q == ST_CALC && div_done && st_d == ST_ARMED)
            cmp_q <= base_q + (per_q - div_rem);
         if (cmp_wr_i) begin
            if (periodic) begin
               per_q <= per_merge;
               if (val_set) cmp_q <= cmp_merge;
            end else begin
               cmp_q <= cmp_merge;
            end
         end
         if (cfg_wr_i && !per_next) per_q <= '0;
      end
   end

   assign fire_o   = fire;
   assign irq_o    = fire && cfg_o[B_IRQ_EN];
   assign cmp_o    = cmp_q;
   assign period_o = per_q;

   assert_fire_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |=> !fire_o);
   assert_oneshot_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_o && !periodic && !rearm) |=> (st_q == ST_IDLE));
   assert_period_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_o[B_PERIOD] |-> (per_q == '0));
   assert_cmp_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_wr_i && periodic && !val_set && !cfg_wr_i) |=> $stable(cmp_o));
   assert_disabled_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(en_i) |-> (st_q == ST_IDLE));
endmodule

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 40;
   localparam int N_RAND     = 20;

   logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
   logic [31:0] cnt = '0, snap = '0;
   logic        cfg_wr = 1'b0, cmp_wr = 1'b0;
   logic [31:0] cfg_d = '0, cfg_m = '0, cmp_d = '0, cmp_m = '0;
   logic        fire_o, irq_o;
   logic [31:0] cfg_o, cmp_o, period_o;

   int n_chk = 0, n_bad = 0, n_fire = 0, base_f = 0;
   bit done = 1'b0;

   tmr_channel i_tmr_channel (
      .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .snap_i(snap), .en_i(en),
      .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_d), .cfg_wmask_i(cfg_m),
      .cmp_wr_i(cmp_wr), .cmp_wdata_i(cmp_d), .cmp_wmask_i(cmp_m),
      .fire_o(fire_o), .irq_o(irq_o), .cfg_o(cfg_o), .cmp_o(cmp_o), .period_o(period_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) if (rst_n && fire_o) n_fire++;

   function automatic logic [31:0] exp_next(logic [31:0] c, logic [31:0] n, logic [31:0] p);
      logic [31:0] d;
      d = n - c;
      return c + (d / p + 32'd1) * p;
   endfunction

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic cfg_w(logic [31:0] d, logic [31:0] m);
      @(negedge clk); cfg_wr = 1'b1; cfg_d = d; cfg_m = m;
      @(negedge clk); cfg_wr = 1'b0; #1;
   endtask

   task automatic cmp_w(logic [31:0] d, logic [31:0] m);
      @(negedge clk); cmp_wr = 1'b1; cmp_d = d; cmp_m = m;
      @(negedge clk); cmp_wr = 1'b0; #1;
   endtask

   task automatic walk(int a, int b, int hold);
      for (int v = a; v <= b; v++) begin
         @(negedge clk); cnt = v;
         repeat (hold - 1) @(negedge clk);
      end
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk("R1", "cfg", cfg_o, 32'h0F04_0010);
      chk("R1", "cmp", cmp_o, 32'hFFFF_FFFF);
      chk("R1", "period", period_o, 0);
      chk("R1", "fire", {fire_o, irq_o}, 0);

      // R2 masked merge, read-only fields, bit 3 forced low
      cfg_w(32'hFFFF_FFFF, 32'h0000_00FF);
      chk("R2", "cfg low byte", cfg_o, 32'h0F04_0017);
      cfg_w(32'h0000_0A00, 32'h0000_1F00);
      chk("R2", "route", cfg_o, 32'h0F04_0A17);
      cfg_w(32'h0, 32'h0000_0001);
      chk("R2", "irq clear", cfg_o, 32'h0F04_0A16);

      // R4 periodic comparator writes, R5 period cleared
      cmp_w(32'd50, '1);
      chk("R4", "period valset", period_o, 50);
      chk("R4", "cmp valset", cmp_o, 50);
      cfg_w(32'h0, 32'h4);
      cmp_w(32'd77, '1);
      chk("R4", "period no valset", period_o, 77);
      chk("R4", "cmp held", cmp_o, 50);
      cfg_w(32'h0, 32'h2);
      chk("R5", "period forced zero", period_o, 0);

      // R3 one-shot comparator writes
      cfg_w(32'h1, 32'h7);
      cmp_w(32'h14, '1);
      chk("R3", "cmp full", cmp_o, 32'h14);
      cmp_w(32'hFFFF_FF05, 32'h0000_00FF);
      chk("R3", "cmp masked", cmp_o, 32'h05);
      cmp_w(32'd20, '1);

      // R6 / R7 one-shot expiry
      @(negedge clk); cnt = 10; snap = 10; en = 1'b1;
      base_f = n_fire;
      walk(11, 19, 1);
      chk("R6", "no early fire", n_fire - base_f, 0);
      @(negedge clk); cnt = 20; #1;
      chk("R6", "fire at match", {fire_o, irq_o}, 2'b11);
      @(negedge clk); #1;
      chk("R6", "fire one cycle", fire_o, 0);
      walk(21, 25, 1);
      chk("R7", "single fire", n_fire - base_f, 1);

      // R8 comparator behind at arming
      @(negedge clk); snap = 22;
      cmp_w(32'd24, '1);
      chk("R8", "late fire", fire_o, 1);
      cmp_w(32'd40, '1);
      chk("R8", "not late", fire_o, 0);

      // R6 interrupt gating
      cfg_w(32'h0, 32'h1);
      base_f = n_fire;
      walk(26, 39, 1);
      @(negedge clk); cnt = 40; #1;
      chk("R6", "gated irq", {fire_o, irq_o}, 2'b10);

      // R11 disabled channel
      @(negedge clk); en = 1'b0;
      cmp_w(32'd50, '1);
      base_f = n_fire;
      walk(41, 50, 1);
      chk("R11", "fire while disabled", fire_o, 0);
      walk(50, 52, 2);
      chk("R11", "no fires", n_fire - base_f, 0);

      // R9 periodic repeat
      cfg_w(32'h7, 32'h7);
      cmp_w(32'd100, '1);
      cfg_w(32'h0, 32'h4);
      cmp_w(32'd10, '1);
      chk("R4", "period set", period_o, 10);
      @(negedge clk); cnt = 90; snap = 90; en = 1'b1;
      base_f = n_fire;
      walk(91, 100, HOLD);
      chk("R9", "first fire", n_fire - base_f, 1);
      chk("R9", "cmp advanced", cmp_o, 110);
      walk(101, 130, HOLD);
      chk("R9", "repeat fires", n_fire - base_f, 4);
      chk("R9", "cmp after repeats", cmp_o, 140);

      // R10 directed late periodic arming
      @(negedge clk); en = 1'b0;
      cfg_w(32'h4, 32'h4);
      cmp_w(32'd7, '1);
      @(negedge clk); cnt = 135; snap = 5; en = 1'b1;
      base_f = n_fire;
      repeat (HOLD) @(negedge clk);
      #1;
      chk("R10", "catch-up cmp", cmp_o, 140);
      chk("R10", "no fire", n_fire - base_f, 0);

      // R10 random catch-up
      for (int k = 0; k < N_RAND; k++) begin
         logic [31:0] c, p, d, r, e;
         c = $urandom;
         p = $urandom_range(1000, 1);
         d = $urandom_range(50000, 1);
         r = $urandom_range(5, 0);
         @(negedge clk); en = 1'b0;
         cfg_w(32'h4, 32'h4);
         cmp_w(c, '1);
         cfg_w(32'h0, 32'h4);
         cmp_w(p, '1);
         @(negedge clk); cnt = c + d; snap = c - r; en = 1'b1;
         base_f = n_fire;
         e = exp_next(c, c + d, p);
         repeat (HOLD) @(negedge clk);
         #1;
         chk("R10", "random catch-up", cmp_o, e);
         chk("R10", "random silent", n_fire - base_f, 0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule